// File: doc/BRIEF.md
# Master Data Staging Buffer

This block holds up to four bytes of data for a byte-level serial transfer engine. A host stages outgoing bytes by writing the data channel and drains incoming bytes by reading it. The engine deposits the bytes of a finished receive transfer in one step, or reports how many stored bytes a finished transmit left counted. Two sticky status flags tell software whether any data is staged and whether the buffer is full. A flush input empties the buffer at once.

Host accesses use a single valid/ready channel carrying both writes and reads. The engine uses its own valid/ready channel. Back-pressure has a fixed rule. `flush` outranks the engine, and the engine outranks the host. `host_ready` is low in any cycle where `flush` or `eng_valid` is high, so a stalled host request stays pending and completes in the first cycle free of both. `eng_ready` is low only while `flush` is high. A host read completes on the handshake edge, and its byte is presented on `host_rdata` during that same cycle. The two flags change only at particular index steps. They are not recomputed from the fill level, so an engine operation can leave them out of step with `fill`.

Top module: `sbuf_master_data`

## Requirements
- R1: After reset, `fill` is 0, both flags are 0 and all four entries in `buf_bytes` are 0x00 (entry i sits at bits [8i+7:8i]).
- R2: An accepted host write with `fill` below 4 stores the byte in entry `fill` and raises `fill` by one on the next cycle.
- R3: An accepted host write with `fill` equal to 4 is dropped: the entries, `fill` and both flags stay unchanged.
- R4: An accepted host read with `fill` above 0 returns entry 0 on `host_rdata` in the handshake cycle. On the next cycle every entry has moved down one position, entry 3 holds 0x00 and `fill` has dropped by one.
- R5: An accepted host read with `fill` equal to 0 returns 0xFF and changes no state.
- R6: `flag_some` is set by a host write taken at `fill` 0. It is cleared by a host read taken at `fill` 1. No other host access changes it.
- R7: `flag_full` is set by a host write taken at `fill` 3. It is cleared by a host read taken at `fill` 4. No other host access changes it.
- R8: A high `flush` clears the buffer on the next edge: `fill` becomes 0, all entries become 0x00 and both flags become 0.
- R9: An accepted engine receive (`eng_rx`=1) of N bytes (`eng_cnt`, clamped to 4) writes `eng_data` byte i into entry i for every i below N, leaves the higher entries unchanged and sets `fill` to N. It sets `flag_some` if N is at least 1 and sets `flag_full` if N is 4. It never clears either flag.
- R10: An accepted engine transmit completion (`eng_rx`=0) sets `fill` to `eng_cnt` (clamped to 4) and leaves the entries and both flags unchanged.
- R11: Priority is flush, then engine, then host. `host_ready` is 0 while `flush` or `eng_valid` is high, and `eng_ready` is 0 while `flush` is high.
- R12: A receive of 0 bytes empties the buffer but leaves a set `flag_some` set. A host read that follows returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and clear both flags |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write (push), 0 = read (pop) |
| host_wdata | input | 8 | Byte to push |
| host_ready | output | 1 | Host access taken this cycle |
| host_rdata | output | 8 | Entry 0, or 0xFF when empty; valid in the handshake cycle |
| eng_valid | input | 1 | Engine completion report |
| eng_rx | input | 1 | 1 = receive load, 0 = transmit completion |
| eng_cnt | input | 3 | Bytes moved by the finished transfer |
| eng_data | input | 32 | Received bytes, byte i at [8i+7:8i] |
| eng_ready | output | 1 | Engine report taken this cycle |
| buf_bytes | output | 32 | All entries, entry i at [8i+7:8i] |
| fill | output | 3 | Number of entries counted as held (index + 1) |
| flag_some | output | 1 | Sticky "data staged" flag |
| flag_full | output | 1 | Sticky "buffer full" flag |

## Verification
Every state change (entries, `fill`, both flags) shows one clock edge after the handshake or flush that caused it. `host_rdata`, `host_ready` and `eng_ready` are combinational and belong to the request cycle. The bench drives requests just after a falling edge. It reads the combinational outputs a moment later, inside the same cycle, and checks the registered results at the next falling edge, after exactly one rising edge. The arbitration scenario holds a stalled host request across two edges and checks that it lands only in the cycle after the engine report.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // One operation is applied to the buffer per cycle.
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_FLUSH  = 3'd1,
    OP_ENG_RX = 3'd2,
    OP_ENG_TX = 3'd3,
    OP_PUSH   = 3'd4,
    OP_POP    = 3'd5
  } sbuf_op_e;
endpackage

// File: rtl/sbuf_arb.sv
module sbuf_arb
  import sbuf_pkg::*;
(
  input  logic     flush,
  input  logic     eng_valid,
  input  logic     eng_rx,
  input  logic     host_valid,
  input  logic     host_write,
  output logic     host_ready,
  output logic     eng_ready,
  output sbuf_op_e op
);
  // Fixed priority: flush > engine > host.
  always_comb begin
    host_ready = !flush && !eng_valid;
    eng_ready  = !flush;
    op         = OP_NONE;
    if (flush)
      op = OP_FLUSH;
    else if (eng_valid)
      op = eng_rx ? OP_ENG_RX : OP_ENG_TX;
    else if (host_valid)
      op = host_write ? OP_PUSH : OP_POP;
  end
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store
  import sbuf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sbuf_op_e            op,
  input  logic [DW-1:0]       push_data,
  input  logic [CW-1:0]       eng_n,
  input  logic [DEPTH*DW-1:0] eng_data,
  output logic [CW-1:0]       cnt,
  output logic [DEPTH*DW-1:0] bytes_flat,
  output logic [DW-1:0]       head
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      unique case (op)
        OP_FLUSH: begin
          cnt <= '0;
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end
        OP_PUSH: begin
          if (cnt < CW'(DEPTH)) begin
            mem[cnt[IW-1:0]] <= push_data;
            cnt              <= cnt + 1'b1;
          end
        end
        OP_POP: begin
          if (cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
            mem[DEPTH-1] <= '0;
            cnt          <= cnt - 1'b1;
          end
        end
        OP_ENG_RX: begin
          for (int i = 0; i < DEPTH; i++)
            if (CW'(i) < eng_n) mem[i] <= eng_data[i*DW +: DW];
          cnt <= eng_n;
        end
        OP_ENG_TX: cnt <= eng_n;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign bytes_flat[g*DW +: DW] = mem[g];
  end

  assign head = (cnt == '0) ? {DW{1'b1}} : mem[0];
endmodule

// File: rtl/sbuf_flags.sv
module sbuf_flags
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sbuf_op_e      op,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] eng_n,
  output logic          some,
  output logic          full
);
  // Flags move only at specific index steps; they are not level decodes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      some <= 1'b0;
      full <= 1'b0;
    end else begin
      unique case (op)
        OP_FLUSH: begin
          some <= 1'b0;
          full <= 1'b0;
        end
        OP_PUSH: begin
          if (cnt == '0)                some <= 1'b1;
          if (cnt == CW'(DEPTH - 1))    full <= 1'b1;
        end
        OP_POP: begin
          if (cnt == CW'(DEPTH))        full <= 1'b0;
          if (cnt == CW'(1))            some <= 1'b0;
        end
        OP_ENG_RX: begin
          if (eng_n != '0)              some <= 1'b1;
          if (eng_n == CW'(DEPTH))      full <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbuf_master_data.sv
module sbuf_master_data
  import sbuf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                host_valid,
  input  logic                host_write,
  input  logic [DW-1:0]       host_wdata,
  output logic                host_ready,
  output logic [DW-1:0]       host_rdata,
  input  logic                eng_valid,
  input  logic                eng_rx,
  input  logic [CW-1:0]       eng_cnt,
  input  logic [DEPTH*DW-1:0] eng_data,
  output logic                eng_ready,
  output logic [DEPTH*DW-1:0] buf_bytes,
  output logic [CW-1:0]       fill,
  output logic                flag_some,
  output logic                flag_full
);
  sbuf_op_e      op;
  logic [CW-1:0] eng_n;

  assign eng_n = (eng_cnt > CW'(DEPTH)) ? CW'(DEPTH) : eng_cnt;

  sbuf_arb u_arb (
    .flush      (flush),
    .eng_valid  (eng_valid),
    .eng_rx     (eng_rx),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_ready (host_ready),
    .eng_ready  (eng_ready),
    .op         (op)
  );

  sbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .push_data  (host_wdata),
    .eng_n      (eng_n),
    .eng_data   (eng_data),
    .cnt        (fill),
    .bytes_flat (buf_bytes),
    .head       (host_rdata)
  );

  sbuf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .cnt   (fill),
    .eng_n (eng_n),
    .some  (flag_some),
    .full  (flag_full)
  );
endmodule

// File: rtl/sbuf_master_data_chk.sv
module sbuf_master_data_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                host_valid,
  input logic                host_write,
  input logic                host_ready,
  input logic [DW-1:0]       host_rdata,
  input logic                eng_valid,
  input logic [DEPTH*DW-1:0] buf_bytes,
  input logic [CW-1:0]       fill,
  input logic                flag_some,
  input logic                flag_full
);
  logic push_acc, pop_acc;
  assign push_acc = host_valid && host_ready && host_write;
  assign pop_acc  = host_valid && host_ready && !host_write;

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && fill < CW'(DEPTH) |=> fill == $past(fill) + 1'b1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && fill == CW'(DEPTH) |=> fill == CW'(DEPTH) && $stable(buf_bytes));

  p_pop_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc && fill != '0 |-> host_rdata == buf_bytes[DW-1:0]);

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc && fill != '0 |=> fill == $past(fill) - 1'b1);

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc && fill == '0 |-> host_rdata == {DW{1'b1}});

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc && fill == '0 |=> fill == '0 && $stable(buf_bytes) && $stable(flag_some));

  p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && fill == CW'(DEPTH - 1) |=> flag_full);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fill == '0 && !flag_some && !flag_full && buf_bytes == '0);

  p_host_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || eng_valid) |-> !host_ready);
endmodule

bind sbuf_master_data sbuf_master_data_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .host_valid (host_valid),
  .host_write (host_write),
  .host_ready (host_ready),
  .host_rdata (host_rdata),
  .eng_valid  (eng_valid),
  .buf_bytes  (buf_bytes),
  .fill       (fill),
  .flag_some  (flag_some),
  .flag_full  (flag_full)
);

// File: tb/sbuf_master_data_tb.sv
`timescale 1ns/1ps
module sbuf_master_data_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ready;
  logic [DW-1:0] host_rdata;
  logic eng_valid = 1'b0, eng_rx = 1'b0;
  logic [CW-1:0] eng_cnt = '0;
  logic [DEPTH*DW-1:0] eng_data = '0;
  logic eng_ready;
  logic [DEPTH*DW-1:0] buf_bytes;
  logic [CW-1:0] fill;
  logic flag_some, flag_full;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sbuf_master_data #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .host_valid(host_valid), .host_write(host_write), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata),
    .eng_valid(eng_valid), .eng_rx(eng_rx), .eng_cnt(eng_cnt), .eng_data(eng_data),
    .eng_ready(eng_ready), .buf_bytes(buf_bytes), .fill(fill),
    .flag_some(flag_some), .flag_full(flag_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic state(input string tag, input int f, input logic s, input logic fu,
                       input logic [31:0] b);
    chk({tag, " fill"}, 32'(fill), 32'(f));
    chk({tag, " some"}, 32'(flag_some), 32'(s));
    chk({tag, " full"}, 32'(flag_full), 32'(fu));
    chk({tag, " bytes"}, buf_bytes, b);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_wdata = b;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0;
    #1 d = host_rdata;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic eng(input logic rx, input int n, input logic [31:0] data);
    @(negedge clk);
    eng_valid = 1'b1; eng_rx = rx; eng_cnt = CW'(n); eng_data = data;
    @(negedge clk);
    eng_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    state("R1 reset", 0, 0, 0, 32'h0);
    chk("R1 host_ready idle", 32'(host_ready), 32'd1);
  endtask

  task automatic t_push_pop();
    logic [7:0] d;
    push(8'hA1);
    state("R2/R6 first push", 1, 1, 0, 32'h000000A1);
    push(8'hB2);
    state("R2 second push", 2, 1, 0, 32'h0000B2A1);
    pop(d);
    chk("R4 pop data", 32'(d), 32'hA1);
    state("R4 shift", 1, 1, 0, 32'h000000B2);
    pop(d);
    chk("R4 pop last", 32'(d), 32'hB2);
    state("R6 some cleared at fill 1", 0, 0, 0, 32'h0);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    push(8'h11); push(8'h22); push(8'h33);
    state("R7 three held", 3, 1, 0, 32'h00332211);
    push(8'h44);
    state("R7 full set", 4, 1, 1, 32'h44332211);
    push(8'h55);
    state("R3 drop on full", 4, 1, 1, 32'h44332211);
    pop(d);
    chk("R4 pop from full", 32'(d), 32'h11);
    state("R7 full cleared", 3, 1, 0, 32'h00443322);
    pop(d); pop(d);
    state("R6 some kept at fill 1", 1, 1, 0, 32'h00000044);
    pop(d);
    chk("R4 pop 44", 32'(d), 32'h44);
    state("R6 some cleared", 0, 0, 0, 32'h0);
    pop(d);
    chk("R5 empty read", 32'(d), 32'hFF);
    state("R5 empty no change", 0, 0, 0, 32'h0);
  endtask

  task automatic t_flush();
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    do_flush();
    state("R8 flush", 0, 0, 0, 32'h0);
  endtask

  task automatic t_rx();
    eng(1'b1, 4, 32'h44332211);
    state("R9 rx four", 4, 1, 1, 32'h44332211);
    do_flush();
    eng(1'b1, 2, 32'hDDCCBBAA);
    state("R9 rx two", 2, 1, 0, 32'h0000BBAA);
    do_flush();
    eng(1'b1, 7, 32'h87654321);
    state("R9 rx clamp", 4, 1, 1, 32'h87654321);
    do_flush();
  endtask

  task automatic t_rx_zero();
    logic [7:0] d;
    push(8'h5A);
    eng(1'b1, 0, 32'hFFFFFFFF);
    state("R12 rx zero keeps some", 0, 1, 0, 32'h0000005A);
    pop(d);
    chk("R12 read after rx zero", 32'(d), 32'hFF);
    state("R12 some still set", 0, 1, 0, 32'h0000005A);
    do_flush();
  endtask

  task automatic t_tx();
    logic [7:0] d;
    push(8'h01); push(8'h02); push(8'h03);
    eng(1'b0, 1, 32'hFFFFFFFF);
    state("R10 tx completion", 1, 1, 0, 32'h00030201);
    pop(d);
    chk("R10 pop after tx", 32'(d), 32'h01);
    state("R6 some cleared after tx", 0, 0, 0, 32'h00000302);
    do_flush();
  endtask

  task automatic t_priority();
    @(negedge clk);
    eng_valid = 1'b1; eng_rx = 1'b1; eng_cnt = CW'(2); eng_data = 32'h0000BBAA;
    host_valid = 1'b1; host_write = 1'b1; host_wdata = 8'h77;
    #1;
    chk("R11 host stalled by engine", 32'(host_ready), 32'd0);
    chk("R11 engine taken", 32'(eng_ready), 32'd1);
    @(negedge clk);
    state("R11 engine first", 2, 1, 0, 32'h0000BBAA);
    eng_valid = 1'b0;
    #1;
    chk("R11 host released", 32'(host_ready), 32'd1);
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
    state("R11 host after engine", 3, 1, 0, 32'h0077BBAA);
    @(negedge clk);
    flush = 1'b1; eng_valid = 1'b1; eng_rx = 1'b1; eng_cnt = CW'(4); eng_data = 32'h12345678;
    #1;
    chk("R11 engine stalled by flush", 32'(eng_ready), 32'd0);
    chk("R11 host stalled by flush", 32'(host_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0; eng_valid = 1'b0;
    state("R11 flush wins", 0, 0, 0, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_overflow();
    t_flush();
    t_rx();
    t_rx_zero();
    t_tx();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule